// File: doc/BRIEF.md
# Split-Width General Register File

This block holds the working registers of a small processor core. Storage is eight 16-bit pairs, and every pair can also be used as two separate 8-bit registers. The result is sixteen byte registers or eight word registers over the same flops. Two read ports and one write port each carry a 4-bit index and a width select. A word access uses the low three index bits to pick a pair. A byte access also uses the top index bit to pick the upper or the lower half of that pair.

The last pair is also the stack pointer. It has its own read port that always shows its full word. It also has an adjust port for push and pop. A push moves the pointer down by two, and the address it presents during that cycle is already lowered. A pop presents the current pointer and moves it up by two at the clock edge.

Reset does not clear the storage. While reset is high, writes and stack adjusts are held off, so the contents stay as they were. Reads are combinational from the stored state. Data written in a cycle appears after the next rising clock edge.

Top module: `gpr_file`

## Requirements
- R1: A word write (width select 1) stores the full 16-bit write data into the pair named by index bits 2:0. A word read of that pair returns it, starting from the first clock edge after the write cycle.
- R2: A byte read (width select 0) returns the upper half (bits 15:8) when index bit 3 is 0 and the lower half (bits 7:0) when it is 1. The byte is placed in bits 7:0 of the read data and bits 15:8 read as zero.
- R3: A byte write stores write data bits 7:0 into the half chosen by index bit 3 (0 upper, 1 lower). The other half of the pair is unchanged.
- R4: For word reads and word writes, index bit 3 is ignored.
- R5: A read in the same cycle as a write to the same register returns the value from before the write.
- R6: The stack read port always shows the full word of pair 7, and pair 7 is also reachable through the normal read and write ports.
- R7: A push (adjust enable with direction 0) shows the stack pointer minus 2 on the stack address output in that cycle, and leaves the pointer decreased by 2 after the edge. The arithmetic wraps modulo 2^16.
- R8: A pop (adjust enable with direction 1) shows the unchanged pointer on the stack address output, and leaves the pointer increased by 2 after the edge. The arithmetic wraps modulo 2^16. Without an adjust, the stack address output equals the pointer.
- R9: If a regular write to pair 7 (byte or word) and a stack adjust happen in the same cycle, the regular write takes effect and the adjust is dropped entirely.
- R10: While reset is high, no write and no stack adjust changes any register. Asserting reset does not clear stored contents.
- R11: The two read ports are independent, and each returns its own register and width in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; blocks updates |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_word | input | 1 | Read port A width: 1 word, 0 byte |
| rd_a_data | output | 16 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_word | input | 1 | Read port B width: 1 word, 0 byte |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_word | input | 1 | Write width: 1 word, 0 byte |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| sp_adj_en | input | 1 | Stack adjust enable |
| sp_adj_dir | input | 1 | Stack adjust direction: 0 push, 1 pop |
| sp_rd_data | output | 16 | Current stack pointer (pair 7) |
| sp_addr | output | 16 | Stack access address for this cycle |

## Verification
Read data and the stack address are combinational, so they are due in the same cycle as their inputs. Register contents change only one rising edge after the write or adjust cycle. The bench drives every input on the falling edge. It checks the same-cycle outputs (old read values, stack address) shortly after driving them and before the rising edge. It checks the updated contents on the following falling edge, which is one full register stage later. A bench model is updated at the point the edge falls, so every expected value refers to the right side of that edge.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    parameter int BYTE_W   = 8;
    parameter int NPAIR    = 8;
    parameter int SP_STEP  = 2;

    localparam int WORD_W  = 2 * BYTE_W;
    localparam int PAIR_W  = $clog2(NPAIR);
    localparam int IDX_W   = PAIR_W + 1;
    localparam int SP_PAIR = NPAIR - 1;

    typedef enum logic {
        SP_PUSH = 1'b0,
        SP_POP  = 1'b1
    } sp_dir_e;

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_WORD = 1'b1
    } acc_size_e;

    typedef struct packed {
        logic              en;
        acc_size_e         size;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        acc_size_e        size;
        logic [IDX_W-1:0] idx;
    } rd_req_t;

    function automatic logic [PAIR_W-1:0] pair_of(input logic [IDX_W-1:0] idx);
        return idx[PAIR_W-1:0];
    endfunction

    function automatic logic low_half(input logic [IDX_W-1:0] idx);
        return idx[IDX_W-1];
    endfunction

endpackage

// File: rtl/gpr_bank.sv
module gpr_bank
    import gpr_pkg::*;
(
    input  logic                               clk,
    input  logic [NPAIR-1:0]                   hi_we,
    input  logic [NPAIR-1:0]                   lo_we,
    input  logic [NPAIR-1:0][BYTE_W-1:0]       hi_d,
    input  logic [NPAIR-1:0][BYTE_W-1:0]       lo_d,
    output logic [NPAIR-1:0][WORD_W-1:0]       q
);

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic [BYTE_W-1:0] hi_q;
        logic [BYTE_W-1:0] lo_q;

        // Contents are intentionally left unreset.
        always_ff @(posedge clk) begin
            if (hi_we[p]) hi_q <= hi_d[p];
        end

        always_ff @(posedge clk) begin
            if (lo_we[p]) lo_q <= lo_d[p];
        end

        assign q[p] = {hi_q, lo_q};
    end

endmodule

// File: rtl/gpr_rd_mux.sv
module gpr_rd_mux
    import gpr_pkg::*;
(
    input  logic [NPAIR-1:0][WORD_W-1:0] pairs,
    input  rd_req_t                      req,
    output logic [WORD_W-1:0]            data
);

    logic [WORD_W-1:0] sel_word;

    always_comb begin
        sel_word = pairs[pair_of(req.idx)];
        if (req.size == ACC_WORD) begin
            data = sel_word;
        end else if (low_half(req.idx)) begin
            data = {{BYTE_W{1'b0}}, sel_word[BYTE_W-1:0]};
        end else begin
            data = {{BYTE_W{1'b0}}, sel_word[WORD_W-1:BYTE_W]};
        end
    end

endmodule

// File: rtl/gpr_sp_ctrl.sv
module gpr_sp_ctrl
    import gpr_pkg::*;
(
    input  logic                rst,
    input  logic [WORD_W-1:0]   sp_q,
    input  logic                adj_en,
    input  sp_dir_e             dir,
    input  logic                wr_hit_sp,
    output logic                adj_take,
    output logic [WORD_W-1:0]   sp_next,
    output logic [WORD_W-1:0]   sp_addr
);

    localparam logic [WORD_W-1:0] STEP = WORD_W'(SP_STEP);

    logic [WORD_W-1:0] sp_dec;
    logic [WORD_W-1:0] sp_inc;

    assign sp_dec = sp_q - STEP;
    assign sp_inc = sp_q + STEP;

    always_comb begin
        sp_next  = (dir == SP_PUSH) ? sp_dec : sp_inc;
        // Push is pre-decrement: the access uses the lowered pointer.
        sp_addr  = (adj_en && dir == SP_PUSH) ? sp_dec : sp_q;
        // A regular write to the stack pair wins over the adjust.
        adj_take = adj_en && !rst && !wr_hit_sp;
    end

endmodule

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode
    import gpr_pkg::*;
(
    input  logic                          rst,
    input  wr_req_t                       wr,
    input  logic                          adj_take,
    input  logic [WORD_W-1:0]             sp_next,
    output logic                          wr_hit_sp,
    output logic [NPAIR-1:0]              hi_we,
    output logic [NPAIR-1:0]              lo_we,
    output logic [NPAIR-1:0][BYTE_W-1:0]  hi_d,
    output logic [NPAIR-1:0][BYTE_W-1:0]  lo_d
);

    logic wr_live;

    assign wr_live   = wr.en && !rst;
    assign wr_hit_sp = wr.en && (pair_of(wr.idx) == PAIR_W'(SP_PAIR));

    always_comb begin
        for (int p = 0; p < NPAIR; p++) begin
            hi_we[p] = 1'b0;
            lo_we[p] = 1'b0;
            hi_d[p]  = wr.data[WORD_W-1:BYTE_W];
            lo_d[p]  = wr.data[BYTE_W-1:0];
            if (wr_live && pair_of(wr.idx) == PAIR_W'(p)) begin
                if (wr.size == ACC_WORD) begin
                    hi_we[p] = 1'b1;
                    lo_we[p] = 1'b1;
                end else if (low_half(wr.idx)) begin
                    lo_we[p] = 1'b1;
                end else begin
                    hi_we[p] = 1'b1;
                    hi_d[p]  = wr.data[BYTE_W-1:0];
                end
            end else if (p == SP_PAIR && adj_take) begin
                hi_we[p] = 1'b1;
                lo_we[p] = 1'b1;
                hi_d[p]  = sp_next[WORD_W-1:BYTE_W];
                lo_d[p]  = sp_next[BYTE_W-1:0];
            end
        end
    end

endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     rd_a_idx,
    input  logic                 rd_a_word,
    output logic [WORD_W-1:0]    rd_a_data,
    input  logic [IDX_W-1:0]     rd_b_idx,
    input  logic                 rd_b_word,
    output logic [WORD_W-1:0]    rd_b_data,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_word,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 sp_adj_en,
    input  logic                 sp_adj_dir,
    output logic [WORD_W-1:0]    sp_rd_data,
    output logic [WORD_W-1:0]    sp_addr
);

    localparam int NRD = 2;

    logic [NPAIR-1:0][WORD_W-1:0] pairs;
    logic [NPAIR-1:0]             hi_we;
    logic [NPAIR-1:0]             lo_we;
    logic [NPAIR-1:0][BYTE_W-1:0] hi_d;
    logic [NPAIR-1:0][BYTE_W-1:0] lo_d;
    logic                         wr_hit_sp;
    logic                         adj_take;
    logic [WORD_W-1:0]            sp_next;
    wr_req_t                      wr;
    rd_req_t [NRD-1:0]            rd_req;
    logic [NRD-1:0][WORD_W-1:0]   rd_data;

    assign wr.en   = wr_en;
    assign wr.size = acc_size_e'(wr_word);
    assign wr.idx  = wr_idx;
    assign wr.data = wr_data;

    assign rd_req[0] = '{size: acc_size_e'(rd_a_word), idx: rd_a_idx};
    assign rd_req[1] = '{size: acc_size_e'(rd_b_word), idx: rd_b_idx};

    gpr_wr_decode u_dec (
        .rst       (rst),
        .wr        (wr),
        .adj_take  (adj_take),
        .sp_next   (sp_next),
        .wr_hit_sp (wr_hit_sp),
        .hi_we     (hi_we),
        .lo_we     (lo_we),
        .hi_d      (hi_d),
        .lo_d      (lo_d)
    );

    gpr_bank u_bank (
        .clk   (clk),
        .hi_we (hi_we),
        .lo_we (lo_we),
        .hi_d  (hi_d),
        .lo_d  (lo_d),
        .q     (pairs)
    );

    gpr_sp_ctrl u_sp (
        .rst       (rst),
        .sp_q      (pairs[SP_PAIR]),
        .adj_en    (sp_adj_en),
        .dir       (sp_dir_e'(sp_adj_dir)),
        .wr_hit_sp (wr_hit_sp),
        .adj_take  (adj_take),
        .sp_next   (sp_next),
        .sp_addr   (sp_addr)
    );

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        gpr_rd_mux u_mux (
            .pairs (pairs),
            .req   (rd_req[r]),
            .data  (rd_data[r])
        );
    end

    assign rd_a_data  = rd_data[0];
    assign rd_b_data  = rd_data[1];
    assign sp_rd_data = pairs[SP_PAIR];

endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk
    import gpr_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [IDX_W-1:0]     rd_a_idx,
    input logic                 rd_a_word,
    input logic [WORD_W-1:0]    rd_a_data,
    input logic                 wr_en,
    input logic [IDX_W-1:0]     wr_idx,
    input logic                 wr_word,
    input logic [WORD_W-1:0]    wr_data,
    input logic                 sp_adj_en,
    input logic                 sp_adj_dir,
    input logic [WORD_W-1:0]    sp_rd_data,
    input logic [WORD_W-1:0]    sp_addr
);

    localparam logic [WORD_W-1:0] STEP = WORD_W'(SP_STEP);

    logic hit_sp;
    assign hit_sp = wr_en && (wr_idx[PAIR_W-1:0] == PAIR_W'(SP_PAIR));

    p_push_move_r7: assert property (@(posedge clk) disable iff (rst)
        sp_adj_en && !sp_adj_dir && !hit_sp |=> sp_rd_data == $past(sp_rd_data) - STEP);

    p_push_addr_r7: assert property (@(posedge clk) disable iff (rst)
        sp_adj_en && !sp_adj_dir |-> sp_addr == sp_rd_data - STEP);

    p_pop_move_r8: assert property (@(posedge clk) disable iff (rst)
        sp_adj_en && sp_adj_dir && !hit_sp |=> sp_rd_data == $past(sp_rd_data) + STEP);

    p_pop_addr_r8: assert property (@(posedge clk) disable iff (rst)
        !(sp_adj_en && !sp_adj_dir) |-> sp_addr == sp_rd_data);

    p_wr_wins_r9: assert property (@(posedge clk) disable iff (rst)
        hit_sp && wr_word && sp_adj_en |=> sp_rd_data == $past(wr_data));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_en && !sp_adj_en |=> $stable(sp_rd_data));

    p_word_view_r6: assert property (@(posedge clk) disable iff (rst)
        rd_a_word && rd_a_idx[PAIR_W-1:0] == PAIR_W'(SP_PAIR) |-> rd_a_data == sp_rd_data);

    p_byte_zext_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_a_word |-> rd_a_data[WORD_W-1:BYTE_W] == '0);

endmodule

bind gpr_file gpr_file_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_a_idx   (rd_a_idx),
    .rd_a_word  (rd_a_word),
    .rd_a_data  (rd_a_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_word    (wr_word),
    .wr_data    (wr_data),
    .sp_adj_en  (sp_adj_en),
    .sp_adj_dir (sp_adj_dir),
    .sp_rd_data (sp_rd_data),
    .sp_addr    (sp_addr)
);

// File: tb/gpr_file_bench.sv
module gpr_file_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic        rd_a_word = 1'b0, rd_b_word = 1'b0, wr_word = 1'b0;
    logic        wr_en = 1'b0, sp_adj_en = 1'b0, sp_adj_dir = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_a_data, rd_b_data, sp_rd_data, sp_addr;

    logic [15:0] mdl [8];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpr_file u_gpr_file (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_word(rd_a_word), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_word(rd_b_word), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word), .wr_data(wr_data),
        .sp_adj_en(sp_adj_en), .sp_adj_dir(sp_adj_dir),
        .sp_rd_data(sp_rd_data), .sp_addr(sp_addr)
    );

    task automatic check16(input string req, input string what,
                           input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [3:0] idx, input logic w);
        logic [15:0] v;
        v = mdl[idx[2:0]];
        if (w) return v;
        return {8'h00, idx[3] ? v[7:0] : v[15:8]};
    endfunction

    function automatic logic [15:0] exp_addr();
        if (sp_adj_en && !sp_adj_dir) return mdl[7] - 16'd2;
        return mdl[7];
    endfunction

    // Inputs are already driven (at a falling edge). Checks same-cycle values,
    // advances the model across the rising edge, returns at the next falling edge.
    task automatic step(input string req);
        bit hit;
        #1;
        check16(req, "same-cycle rd_a", rd_a_data, exp_rd(rd_a_idx, rd_a_word));
        check16(req, "same-cycle sp_addr", sp_addr, exp_addr());
        hit = wr_en && wr_idx[2:0] == 3'd7;
        if (!rst) begin
            if (wr_en) begin
                if (wr_word)        mdl[wr_idx[2:0]]       = wr_data;
                else if (wr_idx[3]) mdl[wr_idx[2:0]][7:0]  = wr_data[7:0];
                else                mdl[wr_idx[2:0]][15:8] = wr_data[7:0];
            end
            if (sp_adj_en && !hit)
                mdl[7] = sp_adj_dir ? mdl[7] + 16'd2 : mdl[7] - 16'd2;
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; sp_adj_en = 0;
    endtask

    task automatic do_wr(input logic [3:0] idx, input logic w, input logic [15:0] d,
                         input string req);
        wr_en = 1; wr_idx = idx; wr_word = w; wr_data = d;
        step(req);
    endtask

    task automatic do_adj(input logic dir, input string req);
        sp_adj_en = 1; sp_adj_dir = dir;
        step(req);
    endtask

    task automatic chk_rd(input logic [3:0] idx, input logic w, input string req);
        rd_a_idx = idx; rd_a_word = w;
        #1;
        check16(req, "rd_a", rd_a_data, exp_rd(idx, w));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: fill every pair by word writes, read back one edge later
        for (int p = 0; p < 8; p++) do_wr(4'(p), 1'b1, 16'h1111 * 16'(p + 1) ^ 16'h0F0F, "R1");
        for (int p = 0; p < 8; p++) chk_rd(4'(p), 1'b1, "R1");

        // R2: byte reads of all sixteen halves
        for (int i = 0; i < 16; i++) chk_rd(4'(i), 1'b0, "R2");

        // R3: byte writes keep the other half
        do_wr(4'b1011, 1'b0, 16'hAA5C, "R3");   // low half of pair 3
        chk_rd(4'd3, 1'b1, "R3");
        do_wr(4'b0101, 1'b0, 16'h33C7, "R3");   // high half of pair 5
        chk_rd(4'd5, 1'b1, "R3");

        // R4: index bit 3 ignored for word access
        do_wr(4'b1110, 1'b1, 16'hBEEF, "R4");
        chk_rd(4'b0110, 1'b1, "R4");
        chk_rd(4'b1110, 1'b1, "R4");

        // R5: same-cycle read returns old value
        rd_a_idx = 4'd2; rd_a_word = 1'b1;
        #1 check16("R5", "before write", rd_a_data, mdl[2]);
        do_wr(4'd2, 1'b1, 16'h5A5A, "R5");
        chk_rd(4'd2, 1'b1, "R5");

        // R6 / R7 / R8: stack pointer
        do_wr(4'd7, 1'b1, 16'h1000, "R6");
        #1 check16("R6", "sp port", sp_rd_data, 16'h1000);
        do_adj(1'b0, "R7");
        #1 check16("R7", "after push", sp_rd_data, 16'h0FFE);
        do_adj(1'b1, "R8");
        #1 check16("R8", "after pop", sp_rd_data, 16'h1000);
        do_wr(4'd7, 1'b1, 16'h0000, "R7");
        do_adj(1'b0, "R7");
        #1 check16("R7", "push wrap", sp_rd_data, 16'hFFFE);
        do_adj(1'b1, "R8");
        #1 check16("R8", "pop wrap", sp_rd_data, 16'h0000);

        // R9: regular write wins over adjust
        do_wr(4'd7, 1'b1, 16'h2000, "R9");
        sp_adj_en = 1; sp_adj_dir = 0;
        do_wr(4'b1111, 1'b0, 16'h0055, "R9");
        #1 check16("R9", "byte write vs push", sp_rd_data, 16'h2055);
        sp_adj_en = 1; sp_adj_dir = 1;
        do_wr(4'd7, 1'b1, 16'h3456, "R9");
        #1 check16("R9", "word write vs pop", sp_rd_data, 16'h3456);

        // R10: reset blocks updates and keeps contents
        rst = 1;
        do_wr(4'd1, 1'b1, 16'hDEAD, "R10");
        do_adj(1'b0, "R10");
        rst = 0;
        chk_rd(4'd1, 1'b1, "R10");
        #1 check16("R10", "sp under reset", sp_rd_data, 16'h3456);

        // R11: two ports at once
        rd_a_idx = 4'd3; rd_a_word = 1; rd_b_idx = 4'b1101; rd_b_word = 0;
        #1;
        check16("R11", "port a", rd_a_data, exp_rd(4'd3, 1'b1));
        check16("R11", "port b", rd_b_data, exp_rd(4'b1101, 1'b0));

        // Random traffic on all ports (R1 R2 R3 R6 R7 R8 R9 R11)
        for (int n = 0; n < 400; n++) begin
            rd_a_idx  = 4'($urandom); rd_a_word = 1'($urandom);
            rd_b_idx  = 4'($urandom); rd_b_word = 1'($urandom);
            wr_en     = 1'($urandom); wr_idx = 4'($urandom);
            wr_word   = 1'($urandom); wr_data = 16'($urandom);
            sp_adj_en = ($urandom % 3) == 0; sp_adj_dir = 1'($urandom);
            #1 check16("R11", "random rd_b", rd_b_data, exp_rd(rd_b_idx, rd_b_word));
            step("R3");
            #1;
            check16("R1", "random rd_a", rd_a_data, exp_rd(rd_a_idx, rd_a_word));
            check16("R6", "random sp", sp_rd_data, mdl[7]);
        end

        done = 1;
        finish_run();
    end

endmodule